// File: doc/BRIEF.md
# Modular-Squaring Pseudorandom Bit Generator

This block is a sequential pseudorandom bit source built on repeated modular squaring. A host presents an odd modulus (meant to be the product of two primes that are each congruent to 3 modulo 4) and a seed that is coprime to it, then pulses `start`. The block squares the seed modulo the modulus to form the initial state. After that it squares the current state modulo the modulus once per step. Each new state gives up its least significant bit as one output bit.

The squaring is done by an iterative shift-add unit that handles one multiplier bit per cycle, so one step costs W+1 clock cycles. Output bits are shifted into a byte register. A one-cycle strobe marks each completed byte. Every state is also shown on a state port with its own strobe. Once started, the generator runs until reset. Further start pulses are ignored. The block does not generate primes, check primality, check coprimality or test statistical quality.

Top module: `bbs_bitgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `busy`, `cfg_err`, `state_valid`, `byte_valid` and `byte_out` (to 0) at that edge.
- R2: A `start` pulse while idle, with a valid configuration, sets `busy` at the next edge. `modulus` and `seed` are captured only at that edge, and later changes on those inputs have no effect.
- R3: The first state reported on `state_out` (with `state_valid` high) is X0 = seed² mod modulus. No output bit is taken from X0.
- R4: Every later reported state is Xi = Xi-1² mod modulus, and every reported state is below the captured modulus.
- R5: The output bit of step i (i ≥ 1) is bit 0 of Xi. Bits are emitted in step order starting with X1.
- R6: Each new bit enters `byte_out` at bit 7 while the older bits move one place toward bit 0. After every eighth bit, `byte_valid` is high for exactly one cycle, and at that cycle `byte_out` holds B1 of the group at bit 0 up to B8 at bit 7.
- R7: A `start` pulse while `busy` is ignored. The sequence continues unchanged, and the block stays busy until reset.
- R8: A `start` while idle is rejected if the modulus is below 3, the modulus is even, or the seed is not below the modulus. A rejected start sets `cfg_err`, and the block stays idle. A later accepted start clears `cfg_err`.
- R9: Successive `state_valid` pulses are exactly W+1 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin generation |
| modulus | input | W | Modulus, captured on an accepted start |
| seed | input | W | Seed, captured on an accepted start |
| busy | output | 1 | Generator running |
| cfg_err | output | 1 | Last start was rejected for a bad configuration |
| state_out | output | W | Most recent state |
| state_valid | output | 1 | One-cycle strobe: new state on `state_out` |
| byte_out | output | 8 | Collected output bits |
| byte_valid | output | 1 | One-cycle strobe: eight new bits in `byte_out` |

## Verification
The assertions check the following on every cycle:
- An accepted start makes the block busy, and a rejected one flags an error and leaves it idle.
- Once busy, the block never leaves that state, and a start pulse while busy leaves the captured modulus untouched.
- Every reported state lies below the modulus.
- The byte strobe never lasts two cycles.

Only the bench scenarios can show the arithmetic itself: the exact value of X0 and of each squared state, which bits are emitted and where they land in each byte, and the W+1 cycle step spacing. The bench compares these against a reference recurrence for several moduli and seeds. These include a 16-bit modulus near the top of the range, a start pulse injected mid-run, and a reset mid-run.

// File: rtl/bbs_pkg.sv
// Package bbs_pkg
// Shared types for the modular-squaring bit generator.
// Assumes nothing beyond the including modules using these names.
package bbs_pkg;

    // Controller phase: idle, forming X0 from the seed, producing bits.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_RUN  = 2'd2
    } bbs_phase_e;

    // Width of the output byte register.
    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/bbs_modsq.sv
// Module bbs_modsq
// Iterative modular squarer: computes (a * a) mod n, MSB-first shift-add,
// one multiplier bit per cycle. A one-cycle go pulse loads the operands.
// The result appears with a one-cycle done pulse W cycles after go is sampled.
// Assumes: n is odd and at least 3, and a < n. The result then lies in [0, n-1].
module bbs_modsq #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] nmod,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [W-1:0]  n_q;
    logic [W-1:0]  acc_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    dbl;
    logic [W:0]    dbl_red;
    logic [W:0]    sum;
    logic [W:0]    sum_red;

    // One interleaved step: acc = (2*acc + bit*a) mod n, two conditional subtracts.
    always_comb begin
        dbl     = {acc_q, 1'b0};
        dbl_red = (dbl >= {1'b0, n_q}) ? dbl - {1'b0, n_q} : dbl;
        sum     = b_q[W-1] ? dbl_red + {1'b0, a_q} : dbl_red;
        sum_red = (sum >= {1'b0, n_q}) ? sum - {1'b0, n_q} : sum;
    end

    // Operand load, iteration and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            n_q   <= '0;
            acc_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                a_q   <= opnd;
                b_q   <= opnd;
                n_q   <= nmod;
                acc_q <= '0;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= sum_red[W-1:0];
                b_q   <= {b_q[W-2:0], 1'b0};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign result = acc_q;

endmodule

// File: rtl/bbs_bytepack.sv
// Module bbs_bytepack
// Collects single bits into a BW-bit register. A new bit enters at the top,
// and older bits move toward bit 0. Pulses byte_valid for one cycle when
// the BW-th bit of a group has entered.
// Assumes bit_en is never high on two consecutive cycles or more (the
// generator guarantees this).
module bbs_bytepack #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          bit_in,
    output logic [BW-1:0] byte_out,
    output logic          byte_valid
);
    localparam int unsigned CW = $clog2(BW);

    logic [BW-1:0] sr_q;
    logic [CW-1:0] cnt_q;

    // Shift in each bit and count bits within the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q       <= '0;
            cnt_q      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (bit_en) begin
                sr_q  <= {bit_in, sr_q[BW-1:1]};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(BW - 1)) begin
                    byte_valid <= 1'b1;
                end
            end
        end
    end

    assign byte_out = sr_q;

endmodule

// File: rtl/bbs_bitgen.sv
// Module bbs_bitgen (top)
// Modular-squaring pseudorandom bit generator. On an accepted start it
// captures the modulus and squares the seed to form X0. It then squares
// the state once per step, emitting bit 0 of each new state into a byte
// packer. It runs until reset.
// Assumes the host supplies a modulus that is a product of suitable primes
// and a seed coprime to it. Only odd/size/range checks are made here.
module bbs_bitgen #(
    parameter int unsigned W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [W-1:0]              modulus,
    input  logic [W-1:0]              seed,
    output logic                      busy,
    output logic                      cfg_err,
    output logic [W-1:0]              state_out,
    output logic                      state_valid,
    output logic [bbs_pkg::BYTE_W-1:0] byte_out,
    output logic                      byte_valid
);
    import bbs_pkg::*;

    bbs_phase_e   ph_q;
    logic [W-1:0] n_q;
    logic [W-1:0] x_q;
    logic         cfg_ok;
    logic         accept;
    logic         sq_go;
    logic         sq_done;
    logic [W-1:0] sq_res;
    logic [W-1:0] sq_opnd;
    logic [W-1:0] sq_n;
    logic         bit_en;

    // Configuration check on the live inputs.
    always_comb begin
        cfg_ok = (modulus >= W'(3)) && modulus[0] && (seed < modulus);
    end

    assign accept  = (ph_q == PH_IDLE) && start && cfg_ok;
    // Launch a squaring on acceptance or right after each completed one.
    assign sq_go   = accept || (sq_done && (ph_q != PH_IDLE));
    assign sq_opnd = (ph_q == PH_IDLE) ? seed : sq_res;
    assign sq_n    = (ph_q == PH_IDLE) ? modulus : n_q;
    assign bit_en  = sq_done && (ph_q == PH_RUN);

    // Phase control, configuration capture and state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_IDLE;
            n_q         <= '0;
            x_q         <= '0;
            cfg_err     <= 1'b0;
            state_valid <= 1'b0;
        end else begin
            state_valid <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            ph_q    <= PH_SEED;
                            n_q     <= modulus;
                            cfg_err <= 1'b0;
                        end else begin
                            cfg_err <= 1'b1;
                        end
                    end
                end
                PH_SEED: begin
                    if (sq_done) begin
                        x_q         <= sq_res;
                        state_valid <= 1'b1;
                        ph_q        <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (sq_done) begin
                        x_q         <= sq_res;
                        state_valid <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (ph_q != PH_IDLE);
    assign state_out = x_q;

    bbs_modsq #(.W(W)) u_sq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sq_go),
        .opnd   (sq_opnd),
        .nmod   (sq_n),
        .done   (sq_done),
        .result (sq_res)
    );

    bbs_bytepack #(.BW(BYTE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (sq_res[0]),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

endmodule

// File: rtl/bbs_bitgen_chk.sv
// Module bbs_bitgen_chk
// Property checker for bbs_bitgen, attached by bind below. It watches the
// ports plus the captured modulus.
// Assumes the synchronous active-low reset of the design.
module bbs_bitgen_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] modulus,
    input logic [W-1:0] seed,
    input logic         busy,
    input logic         cfg_err,
    input logic [W-1:0] state_out,
    input logic         state_valid,
    input logic         byte_valid,
    input logic [W-1:0] n_held
);
    logic good_cfg;
    assign good_cfg = (modulus >= W'(3)) && modulus[0] && (seed < modulus);

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && good_cfg) |=> (busy && !cfg_err)); // R2
    AST_REJECT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !good_cfg) |=> (!busy && cfg_err)); // R8
    AST_STATE_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        state_valid |-> (state_out < n_held)); // R4
    AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R6
    AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(n_held)); // R7
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!state_valid && !byte_valid)); // R5

endmodule

bind bbs_bitgen bbs_bitgen_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .modulus     (modulus),
    .seed        (seed),
    .busy        (busy),
    .cfg_err     (cfg_err),
    .state_out   (state_out),
    .state_valid (state_valid),
    .byte_valid  (byte_valid),
    .n_held      (n_q)
);

// File: tb/tb_bbs_bitgen.sv
module tb_bbs_bitgen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] modulus = '0;
    logic [W-1:0] seed = '0;
    logic         busy;
    logic         cfg_err;
    logic [W-1:0] state_out;
    logic         state_valid;
    logic [7:0]   byte_out;
    logic         byte_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bbs_bitgen #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus), .seed(seed),
        .busy(busy), .cfg_err(cfg_err), .state_out(state_out),
        .state_valid(state_valid), .byte_out(byte_out), .byte_valid(byte_valid)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Run one configuration and check every state and every byte against
    // the reference recurrence x <- x*x mod n.
    task automatic run_case(input longint n, input longint s, input int nbytes, input bit poke);
        longint x;
        int idx = 0;
        int nbits = 0;
        int nb = 0;
        int cyc = 0;
        int last = 0;
        longint acc = 0;
        do_reset();
        @(negedge clk);
        start = 1'b1; modulus = W'(n); seed = W'(s);
        @(negedge clk);
        start = 1'b0; modulus = 16'd100; seed = 16'd7;
        chk(busy === 1'b1 && cfg_err === 1'b0, "R2 busy after start", longint'(busy), 1);
        x = (s * s) % n;
        while (nb < nbytes && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 40) begin start = 1'b1; modulus = 16'd77; seed = 16'd5; end
            if (poke && cyc == 41) start = 1'b0;
            if (state_valid) begin
                if (idx == 0)
                    chk(state_out == W'(x), "R3 initial state", longint'(state_out), x);
                else begin
                    chk(state_out == W'(x), "R4 next state", longint'(state_out), x);
                    chk(cyc - last == W + 1, "R9 step interval", cyc - last, W + 1);
                    acc = acc | ((x & 1) << nbits);
                    nbits++;
                end
                last = cyc;
                idx++;
                x = (x * x) % n;
            end
            if (byte_valid) begin
                chk(nbits == 8, "R6 bits per byte", nbits, 8);
                chk(byte_out == 8'(acc), "R5 R6 byte value", longint'(byte_out), acc);
                acc = 0; nbits = 0; nb++;
            end
        end
        chk(nb == nbytes, "R7 bytes produced", nb, nbytes);
        chk(busy === 1'b1, "R7 still busy", longint'(busy), 1);
    endtask

    task automatic reject_case(input longint n, input longint s);
        do_reset();
        @(negedge clk);
        start = 1'b1; modulus = W'(n); seed = W'(s);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_err === 1'b1 && busy === 1'b0, "R8 rejected config", longint'({cfg_err, busy}), 2);
        // A valid start afterwards clears the flag.
        start = 1'b1; modulus = 16'd209; seed = 16'd3;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err === 1'b0 && busy === 1'b1, "R8 flag cleared", longint'({cfg_err, busy}), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && cfg_err === 1'b0 && state_valid === 1'b0 &&
            byte_valid === 1'b0 && byte_out === 8'h00, "R1 reset state",
            longint'({busy, cfg_err, state_valid, byte_valid, byte_out}), 0);
        rst_n = 1'b1;

        // Small modulus 11*19: several seeds coprime to 209.
        for (int k = 0; k < 6; k++) begin
            int sd;
            sd = 2 + 3 * k;
            if (sd % 11 == 0 || sd % 19 == 0) sd++;
            run_case(209, sd, 4, 1'b0);
        end
        run_case(209, 208, 2, 1'b0);
        run_case(77, 2, 3, 1'b0);
        run_case(59989, 12345, 3, 1'b0);
        run_case(59989, 59988, 2, 1'b0);
        // R7: start while busy is injected mid-run.
        run_case(209, 3, 4, 1'b1);

        // R8: invalid configurations.
        reject_case(210, 3);
        reject_case(1, 0);
        reject_case(209, 209);
        reject_case(209, 300);

        // R1: reset during a run.
        run_case(209, 5, 1, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && byte_valid === 1'b0 && byte_out === 8'h00 && cfg_err === 1'b0,
            "R1 reset mid-run", longint'({busy, byte_valid, byte_out}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && state_valid === 1'b0, "R1 idle after reset",
            longint'({busy, state_valid}), 0);

        report();
    end

endmodule